// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table held in memory. Each table entry is a 32-bit word, and each level is indexed by a 10-bit slice of the virtual address. The block applies every permission rule of the table format while it walks: entry validity, reserved encodings, the user/supervisor split with its user-access override, superpage alignment, the access-type rights and the make-executable-readable override. When a translation succeeds it sets the accessed bit, and for a store also the dirty bit. It writes the entry back to memory before it reports completion.

A requester presents one translation at a time, together with all the context it needs. That context is the access type, the current privilege, the machine-mode redirect flag and its saved privilege, the root page number, the paging enable, and the two override bits. The walker owns a single-outstanding memory port. It holds each read or write request until the memory acknowledges it. It ends every request with a one-cycle completion pulse that carries either a fault or the physical address and the granted read, write and execute rights.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `done`, `fault` and `mem_req` are 0.
- R2: The effective privilege is the input privilege, except when the privilege is machine (3), the access is not a fetch and `req_mprv` is set. In that case `req_mpp` is used instead. If the effective privilege is machine, or `req_paging` is 0, the request completes with `done` one cycle after acceptance. It then returns `paddr` equal to the zero-extended virtual address, grants all three rights, and makes no memory access.
- R3: The first entry address is `req_root_ppn` times 4096, plus vaddr[31:22] times 4. The second-level entry address is the next base plus vaddr[21:12] times 4. Entry fields: V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, page number bits 31:10. Access encodings are fetch 0, load 1 and store 2. Privilege encodings are user 0, supervisor 1 and machine 3.
- R4: An entry with V clear ends the walk with a fault.
- R5: A valid entry with R, W and X all clear points to the next table, whose base is its page number times 4096. Such an entry at the second level is a fault.
- R6: A leaf with W set and R clear is reserved and faults.
- R7: A leaf with U set faults when the effective privilege is not user and either `req_sum` is 0 or the access is a fetch. A leaf with U clear faults unless the effective privilege is supervisor.
- R8: A leaf found at the first level whose page number has a nonzero low 10 bits faults.
- R9: A fetch needs X. A load needs R, or needs X together with `req_mxr`. A store needs W. When the leaf lacks the right the access needs, the request faults.
- R10: On success the entry gets A set, and D set as well for a store. If that changes the entry, the new value is written to the same address before `done`. Otherwise no write occurs.
- R11: For a second-level leaf, the physical address is the page number times 4096 plus vaddr[11:0]. For a first-level leaf, it is page number bits 21:10, then vaddr[21:0].
- R12: The rights granted are these. Read is granted if R is set, or if X and `req_mxr` are both set. Execute is granted if X is set. Write is granted if W is set and either the access is a store or D was already set. On a fault, `paddr` and all three rights are 0.
- R13: A request is accepted only while `req_ready` is 1. Inputs changed after acceptance have no effect. `done` is a one-cycle pulse. Each memory request is held, with a stable address and direction, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Redirect machine data accesses to saved privilege |
| req_mpp | input | 2 | Saved privilege used under redirect |
| req_root_ppn | input | 22 | Page number of the first-level table |
| req_paging | input | 1 | 1 selects two-level translation, 0 bare |
| req_sum | input | 1 | Allow supervisor data access to user pages |
| req_mxr | input | 1 | Treat execute-only pages as readable for loads |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 34 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rdata | input | 32 | Entry read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation failed, valid with done |
| paddr | output | 34 | Physical address, valid with done |
| perm_r | output | 1 | Read right granted |
| perm_w | output | 1 | Write right granted |
| perm_x | output | 1 | Execute right granted |

## Verification
A wrong state in the walker shows first as timing. A level counter or state that is off moves the `done` pulse by two cycles for each extra or missing read, or by one cycle for a spurious or missing write-back. The bench predicts the exact cycle for every request and flags any early or late pulse at once. A corrupted base or level register shows at the next completion, either as a fault where a translation was expected or as a wrong `paddr`. A lost update bit shows in the memory image right after that completion.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_e;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_READ_PTE  = 3'd1,
      ST_WAIT_PTE  = 3'd2,
      ST_WRITE_PTE = 3'd3,
      ST_DONE      = 3'd4
   } walk_st_e;

   localparam logic [1:0] PRIV_USR = 2'd0;
   localparam logic [1:0] PRIV_SUP = 2'd1;
   localparam logic [1:0] PRIV_MCH = 2'd3;

   // entry field positions
   localparam int BIT_V   = 0;
   localparam int BIT_R   = 1;
   localparam int BIT_W   = 2;
   localparam int BIT_X   = 3;
   localparam int BIT_U   = 4;
   localparam int BIT_A   = 6;
   localparam int BIT_D   = 7;
   localparam int PPN_LSB = 10;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } perm_t;

endpackage

// File: rtl/ptw_mode_sel.sv
module ptw_mode_sel
   import ptw_pkg::*;
(
   input  logic [1:0] priv_i,
   input  acc_e       acc_i,
   input  logic       mprv_i,
   input  logic [1:0] mpp_i,
   input  logic       paging_i,
   output logic [1:0] eff_priv_o,
   output logic       bypass_o
);

   always_comb begin
      eff_priv_o = priv_i;
      if (priv_i == PRIV_MCH && acc_i != ACC_FETCH && mprv_i)
         eff_priv_o = mpp_i;
      bypass_o = (eff_priv_o == PRIV_MCH) || !paging_i;
   end

endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
   import ptw_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 34,
   parameter int PTE_W = 32,
   parameter int OFF_W = 12,
   parameter int IDX_W = 10,
   parameter int LVL_W = 1
) (
   input  logic [PTE_W-1:0] pte_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  acc_e             acc_i,
   input  logic [1:0]       eff_priv_i,
   input  logic             sum_i,
   input  logic             mxr_i,
   input  logic [VA_W-1:0]  vaddr_i,
   output logic             is_ptr_o,
   output logic             fault_o,
   output logic             wb_o,
   output logic [PTE_W-1:0] pte_upd_o,
   output logic [PA_W-1:0]  pa_o,
   output perm_t            perm_o
);

   localparam int PPN_W = PA_W - OFF_W;

   logic             v, r, w, x, u, d;
   logic             acc_ok, priv_bad;
   logic [PPN_W-1:0] ppn, vpn, lo_mask;

   always_comb begin
      v   = pte_i[BIT_V];
      r   = pte_i[BIT_R];
      w   = pte_i[BIT_W];
      x   = pte_i[BIT_X];
      u   = pte_i[BIT_U];
      d   = pte_i[BIT_D];
      ppn = pte_i[PTE_W-1:PPN_LSB];
      vpn = PPN_W'(vaddr_i[VA_W-1:OFF_W]);
      // page-number bits that a leaf at this level leaves to the virtual address
      lo_mask = (PPN_W'(1) << (lvl_i * IDX_W)) - PPN_W'(1);

      is_ptr_o = v && !r && !w && !x;

      case (acc_i)
         ACC_FETCH: acc_ok = x;
         ACC_LOAD:  acc_ok = r || (x && mxr_i);
         ACC_STORE: acc_ok = w;
         default:   acc_ok = 1'b0;
      endcase

      if (u) priv_bad = (eff_priv_i != PRIV_USR) && (!sum_i || acc_i == ACC_FETCH);
      else   priv_bad = (eff_priv_i != PRIV_SUP);

      fault_o = !v || (!is_ptr_o && ((w && !r) || priv_bad ||
                                     (|(ppn & lo_mask)) || !acc_ok));

      pte_upd_o        = pte_i;
      pte_upd_o[BIT_A] = 1'b1;
      if (acc_i == ACC_STORE) pte_upd_o[BIT_D] = 1'b1;
      wb_o = (pte_upd_o != pte_i);

      pa_o     = {(ppn & ~lo_mask) | (vpn & lo_mask), vaddr_i[OFF_W-1:0]};
      perm_o.r = r || (x && mxr_i);
      perm_o.x = x;
      perm_o.w = w && (acc_i == ACC_STORE || d);
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 34,
   parameter int PTE_W  = 32,
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 10,
   parameter int LEVELS = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [VA_W-1:0]        req_vaddr,
   input  logic [1:0]             req_acc,
   input  logic [1:0]             req_priv,
   input  logic                   req_mprv,
   input  logic [1:0]             req_mpp,
   input  logic [PA_W-OFF_W-1:0]  req_root_ppn,
   input  logic                   req_paging,
   input  logic                   req_sum,
   input  logic                   req_mxr,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [PA_W-1:0]        mem_addr,
   output logic [PTE_W-1:0]       mem_wdata,
   input  logic [PTE_W-1:0]       mem_rdata,
   input  logic                   mem_ack,
   output logic                   done,
   output logic                   fault,
   output logic [PA_W-1:0]        paddr,
   output logic                   perm_r,
   output logic                   perm_w,
   output logic                   perm_x
);

   localparam int PPN_W  = PA_W - OFF_W;
   localparam int ENT_SH = $clog2(PTE_W / 8);
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;

   // elaboration-time parameter checks
   if (VA_W != OFF_W + LEVELS * IDX_W) begin : g_bad_va
      $error("pt_walker: VA_W must equal OFF_W + LEVELS*IDX_W");
   end
   if (PTE_W - PPN_LSB != PPN_W) begin : g_bad_pte
      $error("pt_walker: entry page-number field must match PA_W - OFF_W");
   end
   if (PPN_W < VA_W - OFF_W) begin : g_bad_pa
      $error("pt_walker: physical page number narrower than virtual");
   end

   walk_st_e         state_q;
   logic [VA_W-1:0]  vaddr_q;
   acc_e             acc_q;
   logic [1:0]       eff_q;
   logic             sum_q, mxr_q;
   logic [PA_W-1:0]  base_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PTE_W-1:0] pte_q;
   logic             fault_q;
   logic [PA_W-1:0]  pa_q;
   perm_t            perm_q;

   acc_e             acc_in;
   logic [1:0]       eff_in;
   logic             bypass_in;
   logic             lf_ptr, lf_fault, lf_wb;
   logic [PTE_W-1:0] lf_pte_upd;
   logic [PA_W-1:0]  lf_pa;
   perm_t            lf_perm;

   assign acc_in = acc_e'(req_acc);

   ptw_mode_sel i_mode_sel (
      .priv_i     (req_priv),
      .acc_i      (acc_in),
      .mprv_i     (req_mprv),
      .mpp_i      (req_mpp),
      .paging_i   (req_paging),
      .eff_priv_o (eff_in),
      .bypass_o   (bypass_in)
   );

   ptw_leaf_check #(
      .VA_W (VA_W), .PA_W (PA_W), .PTE_W (PTE_W),
      .OFF_W(OFF_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
   ) i_leaf_check (
      .pte_i      (pte_q),
      .lvl_i      (lvl_q),
      .acc_i      (acc_q),
      .eff_priv_i (eff_q),
      .sum_i      (sum_q),
      .mxr_i      (mxr_q),
      .vaddr_i    (vaddr_q),
      .is_ptr_o   (lf_ptr),
      .fault_o    (lf_fault),
      .wb_o       (lf_wb),
      .pte_upd_o  (lf_pte_upd),
      .pa_o       (lf_pa),
      .perm_o     (lf_perm)
   );

   // one index slice per table level, level 0 being the last
   logic [IDX_W-1:0] idx_lv [LEVELS];
   for (genvar l = 0; l < LEVELS; l++) begin : g_idx
      assign idx_lv[l] = vaddr_q[OFF_W + l*IDX_W +: IDX_W];
   end

   assign mem_addr  = base_q + (PA_W'(idx_lv[lvl_q]) << ENT_SH);
   assign mem_req   = (state_q == ST_READ_PTE) || (state_q == ST_WRITE_PTE);
   assign mem_we    = (state_q == ST_WRITE_PTE);
   assign mem_wdata = pte_q;
   assign req_ready = (state_q == ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign fault     = fault_q;
   assign paddr     = pa_q;
   assign perm_r    = perm_q.r;
   assign perm_w    = perm_q.w;
   assign perm_x    = perm_q.x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vaddr_q <= '0;
         acc_q   <= ACC_FETCH;
         eff_q   <= '0;
         sum_q   <= 1'b0;
         mxr_q   <= 1'b0;
         base_q  <= '0;
         lvl_q   <= '0;
         pte_q   <= '0;
         fault_q <= 1'b0;
         pa_q    <= '0;
         perm_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               vaddr_q <= req_vaddr;
               acc_q   <= acc_in;
               eff_q   <= eff_in;
               sum_q   <= req_sum;
               mxr_q   <= req_mxr;
               fault_q <= 1'b0;
               if (bypass_in) begin
                  pa_q    <= PA_W'(req_vaddr);
                  perm_q  <= '{r: 1'b1, w: 1'b1, x: 1'b1};
                  state_q <= ST_DONE;
               end else begin
                  base_q  <= {req_root_ppn, {OFF_W{1'b0}}};
                  lvl_q   <= LVL_W'(LEVELS - 1);
                  pa_q    <= '0;
                  perm_q  <= '0;
                  state_q <= ST_READ_PTE;
               end
            end
            ST_READ_PTE: if (mem_ack) begin
               pte_q   <= mem_rdata;
               state_q <= ST_WAIT_PTE;
            end
            ST_WAIT_PTE: begin
               if (lf_ptr) begin
                  if (lvl_q == '0) begin
                     fault_q <= 1'b1;
                     state_q <= ST_DONE;
                  end else begin
                     base_q  <= {pte_q[PTE_W-1:PPN_LSB], {OFF_W{1'b0}}};
                     lvl_q   <= lvl_q - 1'b1;
                     state_q <= ST_READ_PTE;
                  end
               end else if (lf_fault) begin
                  fault_q <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  pa_q   <= lf_pa;
                  perm_q <= lf_perm;
                  if (lf_wb) begin
                     pte_q   <= lf_pte_upd;
                     state_q <= ST_WRITE_PTE;
                  end else begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_WRITE_PTE: if (mem_ack) state_q <= ST_DONE;
            ST_DONE:      state_q <= ST_IDLE;
            default:      state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
   import ptw_pkg::*;
#(
   parameter int PA_W  = 34,
   parameter int PTE_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [PA_W-1:0]  mem_addr,
   input logic [PTE_W-1:0] mem_wdata,
   input logic             done,
   input logic             fault,
   input logic [PA_W-1:0]  paddr,
   input logic             perm_r,
   input logic             perm_w,
   input logic             perm_x
);

   a_r1_idle_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);

   a_r3_entry_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   a_r10_wb_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[BIT_A]);

   a_r12_fault_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (!perm_r && !perm_w && !perm_x && paddr == '0));

   a_r13_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r13_not_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);

   a_r13_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W), .PTE_W(PTE_W)) i_ptw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .done      (done),
   .fault     (fault),
   .paddr     (paddr),
   .perm_r    (perm_r),
   .perm_w    (perm_w),
   .perm_x    (perm_x)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic [1:0]  req_priv = '0;
   logic        req_mprv = 1'b0;
   logic [1:0]  req_mpp = '0;
   logic [21:0] req_root_ppn = '0;
   logic        req_paging = 1'b0;
   logic        req_sum = 1'b0;
   logic        req_mxr = 1'b0;
   logic        mem_req, mem_we;
   logic [33:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        done, fault, perm_r, perm_w, perm_x;
   logic [33:0] paddr;

   pt_walker i_pt_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_priv(req_priv), .req_mprv(req_mprv),
      .req_mpp(req_mpp), .req_root_ppn(req_root_ppn), .req_paging(req_paging),
      .req_sum(req_sum), .req_mxr(req_mxr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .done(done), .fault(fault), .paddr(paddr),
      .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural memory: byte-addressed words, acknowledge one cycle after request
   logic [31:0] mem [logic [33:0]];
   int n_rd = 0;
   int n_wr = 0;

   function automatic logic [31:0] rd(logic [33:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) mem_ack = 1'b0;
      else if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
         mem_ack = 1'b1;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            n_wr++;
         end else begin
            mem_rdata = rd(mem_addr);
            n_rd++;
         end
      end
   end

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // reference expectations
   bit          e_fault;
   logic [33:0] e_pa;
   logic [2:0]  e_perm;
   int          e_lat;
   bit          e_wr;
   logic [33:0] e_wr_addr;
   logic [31:0] e_wr_val;

   task automatic model(logic [31:0] va, logic [1:0] acc, logic [1:0] priv, logic mprv,
                        logic [1:0] mpp, logic [21:0] root, logic pg, logic sum, logic mxr);
      logic [1:0]  ep;
      logic [33:0] base, a;
      logic [31:0] pte, upd;
      logic [21:0] ppn;
      bit          ok;
      e_fault = 0; e_pa = '0; e_perm = '0; e_lat = 1; e_wr = 0;
      ep = (priv == 2'd3 && acc != 2'd0 && mprv) ? mpp : priv;
      if (ep == 2'd3 || !pg) begin
         e_pa = {2'b00, va};
         e_perm = 3'b111;
         return;
      end
      base = {root, 12'h000};
      for (int lv = 1; lv >= 0; lv--) begin
         e_lat += 2;
         a = base + ((lv == 1) ? {22'h0, va[31:22], 2'b00} : {22'h0, va[21:12], 2'b00});
         pte = rd(a);
         ppn = pte[31:10];
         if (!pte[0]) begin e_fault = 1; return; end
         if (pte[3:1] == 3'b000) begin
            if (lv == 0) begin e_fault = 1; return; end
            base = {ppn, 12'h000};
            continue;
         end
         ok = 1;
         if (pte[2] && !pte[1]) ok = 0;
         if (pte[4]) begin
            if (ep != 2'd0 && (!sum || acc == 2'd0)) ok = 0;
         end else if (ep != 2'd1) ok = 0;
         if (lv == 1 && ppn[9:0] != 10'h0) ok = 0;
         case (acc)
            2'd0:    if (!pte[3]) ok = 0;
            2'd1:    if (!(pte[1] || (pte[3] && mxr))) ok = 0;
            default: if (!pte[2]) ok = 0;
         endcase
         if (!ok) begin e_fault = 1; return; end
         upd = pte | 32'h40 | ((acc == 2'd2) ? 32'h80 : 32'h0);
         if (upd != pte) begin
            e_wr = 1; e_wr_addr = a; e_wr_val = upd; e_lat += 1;
         end
         e_pa = (lv == 1) ? {ppn[21:10], va[21:0]} : {ppn, va[11:0]};
         e_perm = {pte[1] | (pte[3] & mxr), pte[2] & ((acc == 2'd2) | pte[7]), pte[3]};
         return;
      end
   endtask

   function automatic logic [31:0] va_of(int i, int j, int off);
      return {i[9:0], j[9:0], off[11:0]};
   endfunction

   // called at a negedge with the walker idle
   task automatic run(string tag, string rq, logic [31:0] va, logic [1:0] acc, logic [1:0] priv,
                      logic mprv, logic [1:0] mpp, logic pg, logic sum, logic mxr, bit hold);
      int rd0, wr0;
      bit early;
      model(va, acc, priv, mprv, mpp, 22'h100, pg, sum, mxr);
      rd0 = n_rd; wr0 = n_wr; early = 0;
      chk(req_ready === 1'b1, "R13", {tag, " ready before request"}, req_ready, 1);
      req_valid = 1; req_vaddr = va; req_acc = acc; req_priv = priv; req_mprv = mprv;
      req_mpp = mpp; req_root_ppn = 22'h100; req_paging = pg; req_sum = sum; req_mxr = mxr;
      @(posedge clk);
      for (int k = 1; k <= e_lat; k++) begin
         @(negedge clk);
         if (hold) req_vaddr = va ^ 32'h0000_E000;   // R13: ignored after acceptance
         else req_valid = 0;
         if (k < e_lat && done) early = 1;
      end
      req_valid = 0;
      chk(!early, "R13", {tag, " early done"}, early, 0);
      chk(done === 1'b1, "R13", {tag, " done at expected cycle"}, done, 1);
      chk(fault === e_fault, rq, {tag, " fault"}, fault, e_fault);
      chk(paddr === e_pa, rq, {tag, " paddr"}, paddr, e_pa);
      chk({perm_r, perm_w, perm_x} === e_perm, rq, {tag, " perms"}, {perm_r, perm_w, perm_x}, e_perm);
      chk((n_wr - wr0) == int'(e_wr), "R10", {tag, " write count"}, n_wr - wr0, e_wr);
      if (e_wr) chk(rd(e_wr_addr) === e_wr_val, "R10", {tag, " written entry"}, rd(e_wr_addr), e_wr_val);
      if (e_lat == 1) chk(n_rd == rd0, "R2", {tag, " no memory read"}, n_rd - rd0, 0);
      @(negedge clk);
      chk(done === 1'b0, "R13", {tag, " done is a pulse"}, done, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         vectors++; miscompares++;
         $display("FAIL R13 watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
      chk(done === 1'b0 && fault === 1'b0, "R1", "done/fault in reset", {done, fault}, 0);
      chk(mem_req === 1'b0, "R1", "mem_req in reset", mem_req, 0);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready === 1'b1 && mem_req === 1'b0, "R1", "idle after reset", {req_ready, mem_req}, 2);

      // first-level table at 0x100000, second-level table at 0x200000
      mem[34'h10_0004] = (32'h200 << 10) | 32'h01;      // i=1 pointer
      mem[34'h10_0008] = (32'hC00 << 10) | 32'h4B;      // i=2 superpage V R X A, aligned
      mem[34'h10_000C] = (32'hC01 << 10) | 32'h43;      // i=3 superpage misaligned
      mem[34'h20_0004] = (32'h12345 << 10) | 32'h53;    // j=1 user R, A
      mem[34'h20_0008] = (32'h00AAA << 10) | 32'h07;    // j=2 sup R W
      mem[34'h20_000C] = (32'h00BBB << 10) | 32'h09;    // j=3 sup X only
      mem[34'h20_0010] = (32'h00CCC << 10) | 32'h05;    // j=4 W only
      mem[34'h20_0014] = (32'h00DDD << 10) | 32'h0D;    // j=5 W X
      mem[34'h20_001C] = (32'h00300 << 10) | 32'h01;    // j=7 pointer at last level
      mem[34'h20_0020] = (32'h00888 << 10) | 32'hD7;    // j=8 user R W A D
      mem[34'h20_0024] = (32'h00999 << 10) | 32'h07;    // j=9 sup R W clean

      //   tag               req   vaddr                 acc   priv  mprv mpp  pg sum mxr hold
      run("mach bypass",    "R2",  32'hDEAD_BEEF,        2'd1, 2'd3, 0, 2'd0, 1, 0, 0, 0);
      run("bare mode",      "R2",  32'h1234_5678,        2'd2, 2'd1, 0, 2'd0, 0, 0, 0, 0);
      run("mprv load",      "R2",  va_of(1, 2, 12'h010), 2'd1, 2'd3, 1, 2'd1, 1, 0, 0, 0);
      run("mprv fetch",     "R2",  va_of(1, 2, 12'h010), 2'd0, 2'd3, 1, 2'd1, 1, 0, 0, 0);
      run("user load",      "R3",  va_of(1, 1, 12'h7FC), 2'd1, 2'd0, 0, 2'd0, 1, 0, 0, 0);
      run("store dirty",    "R10", va_of(1, 2, 12'h004), 2'd2, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("clean load",     "R12", va_of(1, 9, 12'h100), 2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("superpage",      "R11", va_of(2, 12'h155, 12'hABC), 2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("misaligned sp",  "R8",  va_of(3, 0, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("invalid top",    "R4",  va_of(4, 0, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("invalid leaf",   "R4",  va_of(1, 6, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("ptr at last",    "R5",  va_of(1, 7, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("write only",     "R6",  va_of(1, 4, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("write exec",     "R6",  va_of(1, 5, 0),       2'd0, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("user pg sum0",   "R7",  va_of(1, 1, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("user pg sum1",   "R7",  va_of(1, 1, 0),       2'd1, 2'd1, 0, 2'd0, 1, 1, 0, 0);
      run("user pg fetch",  "R7",  va_of(1, 1, 0),       2'd0, 2'd1, 0, 2'd0, 1, 1, 0, 0);
      run("sup pg at user", "R7",  va_of(1, 2, 0),       2'd1, 2'd0, 0, 2'd0, 1, 0, 0, 0);
      run("xonly mxr0",     "R9",  va_of(1, 3, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("xonly mxr1",     "R9",  va_of(1, 3, 0),       2'd1, 2'd1, 0, 2'd0, 1, 0, 1, 0);
      run("xonly fetch",    "R9",  va_of(1, 3, 0),       2'd0, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("store readonly", "R9",  va_of(1, 1, 0),       2'd2, 2'd0, 0, 2'd0, 1, 0, 0, 0);
      run("fetch no x",     "R9",  va_of(1, 2, 0),       2'd0, 2'd1, 0, 2'd0, 1, 0, 0, 0);
      run("held request",   "R13", va_of(1, 8, 12'h020), 2'd1, 2'd0, 0, 2'd0, 1, 0, 0, 1);
      run("store no wb",    "R10", va_of(1, 8, 12'h020), 2'd2, 2'd0, 0, 2'd0, 1, 0, 0, 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule